// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Shadowed Timing

This block produces several independent pulse-width modulated outputs from a single clock. Each output channel is set up through a small word-addressed register file. The setup covers a cycle length (the period), a count of cycles spent at a chosen level (the duty count), and a polarity bit that chooses which level the duty count measures. A start bit runs or halts the channel, an output-enable bit controls the pad driver, and an update bit moves new timing into a channel that is already running.

A channel never runs directly from its programmed registers. When its start bit rises, it copies period, duty and polarity into private working copies. While the channel runs, a register write on its own has no effect. New timing takes effect only after software pulses the update bit high and then low, and only at the next period boundary, so a cycle in progress always finishes. A halted channel holds its inactive level, which is the level opposite to the one the duty count measures.

Top module: `pwm_bank`

## Requirements
- R1: After reset every period register reads 2 and every duty register reads 1. The polarity, start, update and output-enable registers read 0, every `pwm_out` bit is 1 and `pwm_oe` is 0.
- R2: Register map, byte addresses: duty of channel n at n*8, period of channel n at n*8+4, polarity at 0x40, start at 0x44, update at 0x4c, output enable at 0xd0 (bit n = channel n). Period and duty keep only their low 30 bits. Read data appears on `bus_rdata` with `bus_rvalid` one cycle after `bus_rd`.
- R3: A 0-to-1 transition of a channel's start bit loads its working copies. The output then repeats every `period` cycles and spends `duty` cycles of each period at the counted level. The counted level is low when the polarity bit is 0 and high when it is 1.
- R4: Writing period or duty of a running channel, without an update pulse, leaves its waveform unchanged.
- R5: The falling edge of a channel's update bit, while that channel runs, reloads its working copies at the next period boundary. The following periods then use the new values.
- R6: A channel whose start bit is 0 holds its output constantly at the inverse of its polarity bit.
- R7: A duty count of 0 keeps the output at the level opposite to the counted level for the whole period.
- R8: A duty count larger than the period is clamped to the period, so the output stays at the counted level throughout.
- R9: A period value below 2 is loaded as 2.
- R10: A polarity change while a channel runs does not alter its waveform. It takes effect on the next start.
- R11: Bit n of the output-enable register drives `pwm_oe[n]`, which enables the pad driver for channel n.
- R12: A running channel's cycle counter always stays below its working period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that times the counters and the register file |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| bus_rvalid | output | 1 | Marks `bus_rdata` valid, one cycle after `bus_rd` |
| pwm_out | output | NUM_CH | Registered waveform, one bit per channel |
| pwm_oe | output | NUM_CH | Pad driver enable per channel (pad is high impedance when 0) |

## Verification
The bench builds the block with its defaults: four channels, 30-bit timing fields and 8-bit addresses. At these values the 0xd0 enable register and the masking of the two top data bits can both be reached. Period and duty are kept at 20 or fewer cycles, so windows that span whole periods give exact counts of counted-level cycles, whatever the phase. Four channels let one channel be reconfigured while the bench checks that the others keep their own waveform.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  // Byte offsets of the bit-per-channel control words
  localparam int OFS_POL    = 'h40;
  localparam int OFS_START  = 'h44;
  localparam int OFS_DONE   = 'h48;
  localparam int OFS_UPD    = 'h4c;
  localparam int OFS_OE     = 'hd0;
  // Per-channel timing words
  localparam int CH_STRIDE  = 8;
  localparam int PER_OFS    = 4;
  // Values after reset and the shortest legal period
  localparam int RST_PER    = 2;
  localparam int RST_DUTY   = 1;
  localparam int MIN_PERIOD = 2;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 30,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr,
  input  logic                           rd,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic                           rvalid,
  output logic [NUM_CH-1:0][CNT_W-1:0]   per_r,
  output logic [NUM_CH-1:0][CNT_W-1:0]   duty_r,
  output logic [NUM_CH-1:0]              pol_r,
  output logic [NUM_CH-1:0]              start_r,
  output logic [NUM_CH-1:0]              upd_r,
  output logic [NUM_CH-1:0]              oe_r
);
  localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFS_START);
  localparam logic [ADDR_W-1:0] A_UPD   = ADDR_W'(OFS_UPD);
  localparam logic [ADDR_W-1:0] A_OE    = ADDR_W'(OFS_OE);

  logic [DATA_W-1:0] rd_next;
  logic              unused_wbits;
  assign unused_wbits = ^wdata[DATA_W-1:CNT_W];

  // Timing words, one pair per channel
  for (genvar i = 0; i < NUM_CH; i++) begin : g_time
    localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(i * CH_STRIDE);
    localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(i * CH_STRIDE + PER_OFS);
    always_ff @(posedge clk) begin
      if (rst) begin
        duty_r[i] <= CNT_W'(RST_DUTY);
        per_r[i]  <= CNT_W'(RST_PER);
      end else if (wr) begin
        if (addr == A_DUTY) duty_r[i] <= wdata[CNT_W-1:0];
        if (addr == A_PER)  per_r[i]  <= wdata[CNT_W-1:0];
      end
    end
  end

  // Bit-per-channel control words
  always_ff @(posedge clk) begin
    if (rst) begin
      pol_r   <= '0;
      start_r <= '0;
      upd_r   <= '0;
      oe_r    <= '0;
    end else if (wr) begin
      if (addr == A_POL)   pol_r   <= wdata[NUM_CH-1:0];
      if (addr == A_START) start_r <= wdata[NUM_CH-1:0];
      if (addr == A_UPD)   upd_r   <= wdata[NUM_CH-1:0];
      if (addr == A_OE)    oe_r    <= wdata[NUM_CH-1:0];
    end
  end

  // Read selection; the status word at OFS_DONE reads as zero
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i * CH_STRIDE))           rd_next = DATA_W'(duty_r[i]);
      if (addr == ADDR_W'(i * CH_STRIDE + PER_OFS)) rd_next = DATA_W'(per_r[i]);
    end
    if (addr == A_POL)   rd_next = DATA_W'(pol_r);
    if (addr == A_START) rd_next = DATA_W'(start_r);
    if (addr == A_UPD)   rd_next = DATA_W'(upd_r);
    if (addr == A_OE)    rd_next = DATA_W'(oe_r);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_next;
    end
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             pol,
  input  logic             upd,
  input  logic [CNT_W-1:0] per_in,
  input  logic [CNT_W-1:0] duty_in,
  output logic             wave,
  output logic             running,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] duty_o
);
  localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic             run_q, upd_q, pend, pol_s, wave_q;
  logic [CNT_W-1:0] cnt, per_s, duty_s, per_c, duty_c;
  logic             rise, upd_fall, wrap;

  // Legalised values that a load would take
  always_comb begin
    per_c  = (per_in < MIN_PER) ? MIN_PER : per_in;
    duty_c = (duty_in > per_c) ? per_c : duty_in;
  end

  assign rise     = start & ~run_q;
  assign upd_fall = upd_q & ~upd;
  assign wrap     = (cnt == per_s - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      upd_q  <= 1'b0;
      pend   <= 1'b0;
      cnt    <= '0;
      per_s  <= CNT_W'(RST_PER);
      duty_s <= CNT_W'(RST_DUTY);
      pol_s  <= 1'b0;
      wave_q <= 1'b1;
    end else begin
      run_q  <= start;
      upd_q  <= upd;
      // counted level for the first duty_s counts, opposite after
      wave_q <= run_q ? ((cnt < duty_s) ? pol_s : ~pol_s) : ~pol;
      if (!start) begin
        cnt  <= '0;
        pend <= 1'b0;
      end else if (rise) begin
        cnt    <= '0;
        pend   <= 1'b0;
        per_s  <= per_c;
        duty_s <= duty_c;
        pol_s  <= pol;
      end else if (wrap) begin
        cnt  <= '0;
        pend <= 1'b0;
        if (pend || upd_fall) begin
          per_s  <= per_c;
          duty_s <= duty_c;
        end
      end else begin
        cnt <= cnt + ONE;
        if (upd_fall) pend <= 1'b1;
      end
    end
  end

  assign wave    = wave_q;
  assign running = run_q;
  assign cnt_o   = cnt;
  assign per_o   = per_s;
  assign duty_o  = duty_s;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 30,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pwm_oe
);
  logic [NUM_CH-1:0][CNT_W-1:0] per_r, duty_r, cnt_vec, per_s_vec, duty_s_vec;
  logic [NUM_CH-1:0]            pol_bits, start_bits, upd_bits, oe_bits, run_vec;

  pwm_bank_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .rvalid(bus_rvalid),
    .per_r(per_r), .duty_r(duty_r), .pol_r(pol_bits), .start_r(start_bits),
    .upd_r(upd_bits), .oe_r(oe_bits)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    pwm_bank_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .start(start_bits[i]), .pol(pol_bits[i]),
      .upd(upd_bits[i]), .per_in(per_r[i]), .duty_in(duty_r[i]),
      .wave(pwm_out[i]), .running(run_vec[i]), .cnt_o(cnt_vec[i]),
      .per_o(per_s_vec[i]), .duty_o(duty_s_vec[i])
    );
  end

  assign pwm_oe = oe_bits;
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 30
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_CH-1:0]            pol_bits,
  input logic [NUM_CH-1:0]            pwm_out,
  input logic [NUM_CH-1:0]            run,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] per_s,
  input logic [NUM_CH-1:0][CNT_W-1:0] duty_s
);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
    assert_cnt_below_period_R12: assert property (@(posedge clk) disable iff (rst)
      cnt[i] < per_s[i]);
    assert_min_period_R9: assert property (@(posedge clk) disable iff (rst)
      per_s[i] >= TWO);
    assert_duty_clamped_R8: assert property (@(posedge clk) disable iff (rst)
      duty_s[i] <= per_s[i]);
    assert_stopped_level_R6: assert property (@(posedge clk) disable iff (rst)
      !$past(run[i]) |-> pwm_out[i] == !$past(pol_bits[i]));
    assert_reload_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
      !$stable(per_s[i]) |-> cnt[i] == '0);
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .pol_bits(pol_bits), .pwm_out(pwm_out),
  .run(run_vec), .cnt(cnt_vec), .per_s(per_s_vec), .duty_s(duty_s_vec)
);

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int WDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_rvalid;
  logic [NUM_CH-1:0] pwm_out, pwm_oe;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [3:0] pol_v = '0, start_v = '0, upd_v = '0;

  typedef struct { logic [DATA_W-1:0] exp; string req; } item_t;
  item_t sbq[$];
  item_t it;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_bank u_pwm_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: issue a read and queue its expected data
  task automatic rd(int a, logic [DATA_W-1:0] e, string req);
    item_t x;
    @(negedge clk);
    x.exp = e; x.req = req;
    sbq.push_back(x);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: compare each returned word against the queue head
  always @(negedge clk) begin
    if (bus_rvalid === 1'b1) begin
      total++;
      if (sbq.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected read data actual=%0h expected=none", bus_rdata);
      end else begin
        it = sbq.pop_front();
        if (bus_rdata !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%0h expected=%0h", it.req, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic count_high(int ch, int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[ch] === 1'b1) h++;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h;
    idle(4);
    rst = 1'b0;
    idle(2);
    // R1: reset state
    chk("R1 outputs idle high", int'(pwm_out), 15);
    chk("R1 pad enables off", int'(pwm_oe), 0);
    rd('h04, 2, "R1 period reset");
    rd('h18, 1, "R1 duty reset");
    rd('h44, 0, "R1 start reset");
    rd('h40, 0, "R1 polarity reset");
    // R2: field width masking
    wr('h1c, 32'hFFFF_FFFF);
    rd('h1c, 32'h3FFF_FFFF, "R2 period masked to 30 bits");
    wr('h18, 32'hC000_0005);
    rd('h18, 5, "R2 duty masked to 30 bits");
    // R3: ch0 high-counted, ch1 low-counted
    wr('h04, 10); wr('h00, 3);
    wr('h0c, 8);  wr('h08, 3);
    pol_v = 4'b0001; wr('h40, 32'(pol_v));
    start_v = 4'b0011; wr('h44, 32'(start_v));
    idle(6);
    count_high(0, 40, h); chk("R3 ch0 pol1 per10 duty3", h, 12);
    count_high(1, 32, h); chk("R3 ch1 pol0 per8 duty3", h, 20);
    // R6: stopped channel, then polarity flip while stopped
    count_high(2, 10, h); chk("R6 ch2 stopped pol0 holds high", h, 10);
    pol_v = 4'b0101; wr('h40, 32'(pol_v));
    idle(3);
    count_high(2, 10, h); chk("R6 ch2 stopped pol1 holds low", h, 0);
    // R7: zero duty
    wr('h14, 6); wr('h10, 0);
    start_v = 4'b0111; wr('h44, 32'(start_v));
    idle(6);
    count_high(2, 24, h); chk("R7 ch2 duty0 stays opposite", h, 0);
    // R8: duty above period
    wr('h1c, 5); wr('h18, 9);
    pol_v = 4'b1101; wr('h40, 32'(pol_v));
    start_v = 4'b1111; wr('h44, 32'(start_v));
    idle(6);
    count_high(3, 20, h); chk("R8 ch3 duty clamped", h, 20);
    // R9: period below minimum on ch2
    start_v = 4'b1011; wr('h44, 32'(start_v));
    idle(3);
    wr('h14, 0); wr('h10, 1);
    start_v = 4'b1111; wr('h44, 32'(start_v));
    idle(6);
    count_high(2, 20, h); chk("R9 ch2 period0 runs as 2", h, 10);
    // R4: registers rewritten without update
    wr('h04, 20); wr('h00, 15);
    idle(12);
    count_high(0, 40, h); chk("R4 ch0 unchanged without update", h, 12);
    count_high(1, 32, h); chk("R4 ch1 unaffected by ch0 writes", h, 20);
    // R5: update pulse
    upd_v = 4'b0001; wr('h4c, 32'(upd_v));
    upd_v = 4'b0000; wr('h4c, 32'(upd_v));
    idle(25);
    count_high(0, 40, h); chk("R5 ch0 reloaded per20 duty15", h, 30);
    // R10: polarity change while running
    pol_v = 4'b1111; wr('h40, 32'(pol_v));
    idle(10);
    count_high(1, 32, h); chk("R10 ch1 ignores running polarity change", h, 20);
    start_v = 4'b1101; wr('h44, 32'(start_v));
    idle(3);
    start_v = 4'b1111; wr('h44, 32'(start_v));
    idle(6);
    count_high(1, 32, h); chk("R10 ch1 restart applies polarity", h, 12);
    // R6: stop a running channel
    start_v = 4'b1110; wr('h44, 32'(start_v));
    idle(4);
    count_high(0, 20, h); chk("R6 ch0 stopped holds inactive", h, 0);
    // R11: pad enables
    wr('hd0, 32'h5);
    idle(1);
    chk("R11 pad enables follow register", int'(pwm_oe), 5);
    rd('hd0, 5, "R11 enable readback");
    idle(4);
    chk("R2 all reads answered", sbq.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule